// File: doc/BRIEF.md
# Linked Shadow-Register Write Fabric for a PWM Channel Bank

This block sits between a simple register bus and a bank of PWM channels. Each channel keeps five timing values: period and compare values A through D. Each value has a shadow copy that the bus writes and an active copy that the channel's own counter event loads from the shadow. The counter, the compare events and the waveform logic are outside this block. Only the per-channel load strobe comes in.

Each channel also has a link configuration register. It holds one small field for each of the five value kinds. A non-zero field makes that channel follow another channel for that kind. A bus write that reaches the followed channel through the mirror address window is then stored, in the same clock cycle, in the followed channel and in every follower. Because of this, a load strobe in any channel can never catch some followers holding the new value and others holding the old one.

Writes through the primary addresses reach only the addressed channel. The link configuration and the shadow values can be read back through a combinational read port.

Top module: `pwm_link_fabric`

## Requirements
- R1: After reset, every shadow value, every active value and every link field reads as zero.
- R2: A write with `wr_en` high to address `{channel, offset}` updates exactly one shadow: the one at that channel and that kind. The offset is `wr_addr[3:0]`, and offsets 0 to 4 select period, A, B, C and D in the primary window. The channel's followers are left unchanged.
- R3: A write to mirror offset 8+k (k = 0 period, 1 A, 2 B, 3 C, 4 D) at channel S updates shadow k of channel S. In the same cycle it updates shadow k of every channel whose link field k holds S+1.
- R4: A link field of 0, or any value above the number of channels, links nothing. Such a channel changes only on its own direct writes.
- R5: Link fields act per kind. Following channel S for kind k has no effect on the other kinds.
- R6: A link field that names its own channel (own index + 1) has the same effect as no link. A mirror write to that channel updates only that channel.
- R7: A high `load_i[c]` copies all five shadows of channel c into its active values at that edge. If a write lands on the same edge, the active value takes the shadow value from before that write.
- R8: `rd_data` shows, with no clock delay, the value at the addressed channel. Offsets 0 to 4 and 8 to 12 give the shadow, offset 5 gives the link register (zero-extended), and every other offset reads 0.
- R9: A write to offset 5 stores link field k from bits `[3k+2:3k]` of the data. The new links apply from the next write onward.
- R10: Linking is one level deep. A mirror write reaches the direct followers of a channel but not the followers of those followers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 6 | Write address {channel[1:0], offset[3:0]} |
| wr_data | input | 16 | Write data |
| rd_addr | input | 6 | Read address, same layout as the write address |
| rd_data | output | 16 | Combinational readback |
| load_i | input | 4 | Per-channel shadow-to-active load strobe |
| active_o | output | 320 | Active values; channel c kind k is at bits [(c*5+k)*16 +: 16] |

## Verification
On every cycle the assertions check the following: a shadow without a write enable holds its value, at most one channel is addressed directly per kind, follower updates appear only during mirror-window writes, the link register holds between its writes, and loads copy the previous shadows. Some properties need both the write pattern and the link state to produce, so only the bench scenarios can show them. These are the fan-out to several followers, the ignored out-of-range and self link values, the one-level limit on chains, and a configuration change taking effect on the very next write. A behavioural model follows every cycle of these scenarios and of a random phase, and the bench compares it against all outputs and all readback values.

// File: rtl/pwm_link_pkg.sv
`timescale 1ns/100ps
package pwm_link_pkg;
   localparam int NUM_KIND  = 5;          // period, A, B, C, D
   localparam int OFF_W     = 4;          // low address bits select the register
   localparam logic [3:0] OFF_LINK = 4'd5;
   localparam int OFF_MIR   = 8;          // mirror window base
endpackage

// File: rtl/link_decode.sv
`timescale 1ns/100ps
module link_decode
   import pwm_link_pkg::*;
#(
   parameter int NUM_CH = 4,
   localparam int CH_W   = $clog2(NUM_CH),
   localparam int ADDR_W = CH_W + OFF_W
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [ADDR_W-1:0]          wr_addr,
   output logic [NUM_CH*NUM_KIND-1:0] direct_we,
   output logic [NUM_KIND-1:0]        mir_we,
   output logic [CH_W-1:0]            src_ch,
   output logic [NUM_CH-1:0]          cfg_we
);
   logic [OFF_W-1:0] off;

   assign off    = wr_addr[OFF_W-1:0];
   assign src_ch = wr_addr[ADDR_W-1:OFF_W];

   always_comb begin
      direct_we = '0;
      mir_we    = '0;
      cfg_we    = '0;
      if (wr_en && int'(src_ch) < NUM_CH) begin
         for (int k = 0; k < NUM_KIND; k++) begin
            if (off == OFF_W'(k) || off == OFF_W'(OFF_MIR + k))
               direct_we[int'(src_ch)*NUM_KIND + k] = 1'b1;
            if (off == OFF_W'(OFF_MIR + k))
               mir_we[k] = 1'b1;
         end
         if (off == OFF_LINK)
            cfg_we[src_ch] = 1'b1;
      end
   end

   // R2: a bus write addresses at most one register directly
   p_direct_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(direct_we));
endmodule

// File: rtl/link_fanout.sv
`timescale 1ns/100ps
module link_fanout
   import pwm_link_pkg::*;
#(
   parameter int NUM_CH = 4,
   localparam int CH_W   = $clog2(NUM_CH),
   localparam int LINK_W = $clog2(NUM_CH + 1)
) (
   input  logic [NUM_CH*NUM_KIND*LINK_W-1:0] link_cfg,
   input  logic [NUM_KIND-1:0]               mir_we,
   input  logic [CH_W-1:0]                   src_ch,
   input  logic [NUM_CH*NUM_KIND-1:0]        direct_we,
   output logic [NUM_CH*NUM_KIND-1:0]        sh_we
);
   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      for (genvar k = 0; k < NUM_KIND; k++) begin : g_kind
         localparam int IDX = c*NUM_KIND + k;
         logic [LINK_W-1:0] fld;
         logic              follows;
         assign fld = link_cfg[IDX*LINK_W +: LINK_W];
         // field v>0 names channel v-1; out of range or self means no link
         assign follows = (fld != '0) && (int'(fld) <= NUM_CH)
                       && (int'(fld) - 1 == int'(src_ch))
                       && (int'(fld) - 1 != c);
         assign sh_we[IDX] = direct_we[IDX] | (mir_we[k] & follows);
      end
   end
endmodule

// File: rtl/link_reg_bank.sv
`timescale 1ns/100ps
module link_reg_bank
   import pwm_link_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int CFG_W  = 15
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_KIND-1:0]        sh_we,
   input  logic                       cfg_we,
   input  logic                       load,
   input  logic [DATA_W-1:0]          wr_data,
   output logic [NUM_KIND*DATA_W-1:0] shadow,
   output logic [NUM_KIND*DATA_W-1:0] active,
   output logic [CFG_W-1:0]           cfg
);
   logic [NUM_KIND-1:0][DATA_W-1:0] sh_q, act_q;
   logic [CFG_W-1:0]                cfg_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q  <= '0;
         act_q <= '0;
         cfg_q <= '0;
      end else begin
         for (int k = 0; k < NUM_KIND; k++)
            if (sh_we[k]) sh_q[k] <= wr_data;
         if (load)   act_q <= sh_q;
         if (cfg_we) cfg_q <= wr_data[CFG_W-1:0];
      end
   end

   assign shadow = sh_q;
   assign active = act_q;
   assign cfg    = cfg_q;

   p_reset_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> (sh_q == '0 && act_q == '0 && cfg_q == '0));

   p_load_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (act_q == $past(sh_q)));

   p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we |=> $stable(cfg_q));

   for (genvar k = 0; k < NUM_KIND; k++) begin : g_hold
      p_shadow_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
         !sh_we[k] |=> $stable(sh_q[k]));
   end
endmodule

// File: rtl/pwm_link_fabric.sv
`timescale 1ns/100ps
module pwm_link_fabric
   import pwm_link_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int DATA_W = 16,
   localparam int CH_W   = $clog2(NUM_CH),
   localparam int ADDR_W = CH_W + OFF_W
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              wr_en,
   input  logic [ADDR_W-1:0]                 wr_addr,
   input  logic [DATA_W-1:0]                 wr_data,
   input  logic [ADDR_W-1:0]                 rd_addr,
   output logic [DATA_W-1:0]                 rd_data,
   input  logic [NUM_CH-1:0]                 load_i,
   output logic [NUM_CH*NUM_KIND*DATA_W-1:0] active_o
);
   localparam int LINK_W = $clog2(NUM_CH + 1);
   localparam int CFG_W  = NUM_KIND * LINK_W;

   if (NUM_CH < 2)      begin : g_bad_ch  $error("NUM_CH must be at least 2"); end
   if (CFG_W > DATA_W)  begin : g_bad_cfg $error("link register wider than data bus"); end

   logic [NUM_CH*NUM_KIND-1:0]        direct_we, sh_we;
   logic [NUM_KIND-1:0]               mir_we;
   logic [CH_W-1:0]                   src_ch;
   logic [NUM_CH-1:0]                 cfg_we;
   logic [NUM_CH*CFG_W-1:0]           cfg_all;
   logic [NUM_CH*NUM_KIND*DATA_W-1:0] shadow_all;

   link_decode #(.NUM_CH(NUM_CH)) u_dec (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .direct_we(direct_we), .mir_we(mir_we), .src_ch(src_ch), .cfg_we(cfg_we));

   link_fanout #(.NUM_CH(NUM_CH)) u_fan (
      .link_cfg(cfg_all), .mir_we(mir_we), .src_ch(src_ch),
      .direct_we(direct_we), .sh_we(sh_we));

   for (genvar c = 0; c < NUM_CH; c++) begin : g_bank
      link_reg_bank #(.DATA_W(DATA_W), .CFG_W(CFG_W)) u_bank (
         .clk(clk), .rst_n(rst_n),
         .sh_we(sh_we[c*NUM_KIND +: NUM_KIND]),
         .cfg_we(cfg_we[c]), .load(load_i[c]), .wr_data(wr_data),
         .shadow(shadow_all[c*NUM_KIND*DATA_W +: NUM_KIND*DATA_W]),
         .active(active_o[c*NUM_KIND*DATA_W +: NUM_KIND*DATA_W]),
         .cfg(cfg_all[c*CFG_W +: CFG_W]));
   end

   // combinational readback of the addressed channel
   logic [CH_W-1:0]  rd_ch;
   logic [OFF_W-1:0] rd_off;
   assign rd_ch  = rd_addr[ADDR_W-1:OFF_W];
   assign rd_off = rd_addr[OFF_W-1:0];

   always_comb begin
      rd_data = '0;
      if (int'(rd_ch) < NUM_CH) begin
         for (int k = 0; k < NUM_KIND; k++)
            if (rd_off == OFF_W'(k) || rd_off == OFF_W'(OFF_MIR + k))
               rd_data = shadow_all[(int'(rd_ch)*NUM_KIND + k)*DATA_W +: DATA_W];
         if (rd_off == OFF_LINK)
            rd_data = DATA_W'(cfg_all[int'(rd_ch)*CFG_W +: CFG_W]);
      end
   end

   // R3: a follower update only happens during a mirror-window write
   p_link_needs_mirror_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((sh_we & ~direct_we) != '0) |->
         (wr_en && wr_addr[OFF_W-1:0] >= OFF_W'(OFF_MIR)
                && wr_addr[OFF_W-1:0] <  OFF_W'(OFF_MIR + NUM_KIND)));
endmodule

// File: tb/tb_pwm_link_fabric.sv
`timescale 1ns/100ps
module tb_pwm_link_fabric;
   localparam int NC = 4;
   localparam int NK = 5;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [5:0]    wr_addr = '0;
   logic [15:0]   wr_data = '0;
   logic [5:0]    rd_addr = '0;
   logic [15:0]   rd_data;
   logic [3:0]    load_i = '0;
   logic [NC*NK*DW-1:0] active_o;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // reference model
   int m_sh [NC][NK];
   int m_act[NC][NK];
   int m_lk [NC][NK];

   always #5 clk = ~clk;

   pwm_link_fabric dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .load_i(load_i), .active_o(active_o));

   task automatic chk(input string tag, input string what,
                      input logic [15:0] got, input logic [15:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
      end
   endtask

   function automatic int pack_link(int c);
      int v = 0;
      for (int k = 0; k < NK; k++) v |= (m_lk[c][k] & 7) << (3*k);
      return v;
   endfunction

   function automatic int lnk(int k, int v);
      return (v & 7) << (3*k);
   endfunction

   // behavioural next state, computed from pre-edge state
   task automatic model(input bit we, input int a, input int d, input int ld);
      int osh[NC][NK];
      int olk[NC][NK];
      int ch, off;
      osh = m_sh; olk = m_lk;
      for (int c = 0; c < NC; c++)
         if (ld[c]) for (int k = 0; k < NK; k++) m_act[c][k] = osh[c][k];
      if (we) begin
         ch = a >> 4; off = a & 15;
         if (off < NK) m_sh[ch][off] = d;
         else if (off == 5)
            for (int k = 0; k < NK; k++) m_lk[ch][k] = (d >> (3*k)) & 7;
         else if (off >= 8 && off < 8 + NK) begin
            m_sh[ch][off-8] = d;
            for (int c = 0; c < NC; c++)
               if (olk[c][off-8] == ch + 1) m_sh[c][off-8] = d;
         end
      end
   endtask

   task automatic check_all(input string tag);
      for (int c = 0; c < NC; c++) begin
         for (int k = 0; k < NK; k++) begin
            chk(tag, $sformatf("active ch%0d k%0d", c, k),
                active_o[(c*NK+k)*DW +: DW], 16'(m_act[c][k]));
            rd_addr = 6'((c << 4) | k);
            #0.1;
            chk(tag, $sformatf("shadow ch%0d k%0d", c, k), rd_data, 16'(m_sh[c][k]));
         end
         rd_addr = 6'((c << 4) | 5);
         #0.1;
         chk(tag, $sformatf("link ch%0d", c), rd_data, 16'(pack_link(c)));
      end
   endtask

   task automatic step(input bit we, input int a, input int d, input int ld,
                       input string tag);
      @(negedge clk);
      wr_en = we; wr_addr = 6'(a); wr_data = 16'(d); load_i = 4'(ld);
      @(posedge clk);
      model(we, a, d, ld);
      #1;
      wr_en = 1'b0; load_i = '0;
      check_all(tag);
   endtask

   function automatic int A(int ch, int off);
      return (ch << 4) | off;
   endfunction

   initial begin
      for (int c = 0; c < NC; c++)
         for (int k = 0; k < NK; k++) begin
            m_sh[c][k] = 0; m_act[c][k] = 0; m_lk[c][k] = 0;
         end
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      #1 check_all("R1");

      // R9: channels 1 and 2 follow channel 0 for compare A (kind 1)
      step(1, A(1,5), lnk(1,1), 0, "R9");
      step(1, A(2,5), lnk(1,1), 0, "R9");
      // R2: primary window write stays local
      step(1, A(0,1), 16'h1111, 0, "R2");
      // R3: mirror write fans out to both followers
      step(1, A(0,9), 16'h2222, 0, "R3");
      // R5: period of channel 0 is not linked for anyone
      step(1, A(0,8), 16'h3333, 0, "R5");
      // R4: out-of-range field on ch3 compare C, zero field on compare B
      step(1, A(3,5), lnk(3,7), 0, "R4");
      for (int c = 0; c < NC; c++) step(1, A(c,11), 16'h4400 + c, 0, "R4");
      step(1, A(0,10), 16'h5555, 0, "R4");
      // R6: self link on ch2 compare D
      step(1, A(2,5), lnk(1,1) | lnk(4,3), 0, "R6");
      step(1, A(2,12), 16'h6666, 0, "R6");
      // R10: ch1 period follows ch0, ch3 period follows ch1
      step(1, A(1,5), lnk(0,1) | lnk(1,1), 0, "R10");
      step(1, A(3,5), lnk(0,2), 0, "R10");
      step(1, A(0,8), 16'h7777, 0, "R10");
      step(1, A(1,8), 16'h8888, 0, "R10");
      // R9: link change then mirror write on the next cycle
      step(1, A(3,5), lnk(0,1), 0, "R9");
      step(1, A(0,8), 16'h9999, 0, "R9");
      // R7: load, and load coinciding with a write
      step(0, 0, 0, 4'hF, "R7");
      step(1, A(0,9), 16'hABCD, 4'b0111, "R7");
      step(0, 0, 0, 4'b0110, "R7");
      // R8: unmapped offsets read zero
      foreach (m_sh[c]) begin
         int offs[5] = '{6, 7, 13, 14, 15};
         foreach (offs[i]) begin
            rd_addr = 6'(A(c, offs[i]));
            #0.1;
            chk("R8", $sformatf("unmapped ch%0d off%0d", c, offs[i]), rd_data, 16'h0);
         end
      end
      // random traffic across all requirements (R3 fan-out dominant)
      for (int i = 0; i < 400; i++) begin
         int offs[11] = '{0, 1, 2, 3, 4, 5, 8, 9, 10, 11, 12};
         int o = offs[$urandom % 11];
         int d = (o == 5) ? int'($urandom % 32768) : int'($urandom % 65536);
         step($urandom % 4 != 0, A($urandom % NC, o), d, $urandom % 16, "R3");
      end
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #2000000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule